// File: doc/BRIEF.md
# Fan Management Register Target on a Two-Wire Serial Bus

This block is a two-wire serial bus target (I2C, standard mode) that gives a bus master access to a small fan management register file. It answers only at 7-bit address 0x74. After its address, a write transfer carries a register pointer byte and then any number of data bytes. A read transfer returns bytes starting at the pointer that the last write set. The pointer moves forward after every data byte and wraps around after the last register.

Writes and reads at the same register index reach different storage. Index 0 holds the fan enable mask in both directions. Writes to indices 1 to 3 set the PWM duty percentage of fans 1 to 3, and reads from the same indices return the measured speed (revolutions per second) that the tachometer logic presents on an input. The block only pulls SDA low and leaves the high level to the external pull-up. SCL is input only, and the block never stretches the clock.

Both bus lines are sampled with two flip-flops in the system clock domain. A START or STOP is recognised as a change on SDA while SCL is high. All SDA drive changes happen on a detected falling edge of SCL.

Top module: `fanI2cTarget`

## Requirements
- R1: Only the 7-bit address 0x74 (address byte 0xE8 for write, 0xE9 for read) is acknowledged. A transfer to any other address is not acknowledged, its later bytes change no register, and SDA is not driven during it.
- R2: The first byte after a write address is the register pointer. Values 0 to 3 select that register, and any value above 3 selects register 0.
- R3: Register 0 is the fan enable mask: bit 0, bit 1 and bit 2 enable fans 1, 2 and 3 on `fanEnable[0]`, `fanEnable[1]` and `fanEnable[2]`. A read of register 0 returns the mask in bits 2:0, with bits 7:3 zero.
- R4: Writes to registers 1, 2 and 3 set the duty of fans 1, 2 and 3 on `fanDuty[7:0]`, `fanDuty[15:8]` and `fanDuty[23:16]`. A value above 100 is stored as 100, and 0 to 100 are stored as written.
- R5: Reads of registers 1, 2 and 3 return `tachRps[7:0]`, `tachRps[15:8]` and `tachRps[23:16]` respectively, and never the stored duty.
- R6: After reset the enable mask is 3'b111, every duty is 30, and SDA is released.
- R7: The pointer advances by one after every data byte, read or written, and wraps from register 3 to register 0.
- R8: The target pulls SDA low during the ninth clock after its own address byte, the pointer byte and every written data byte. When sending read data it releases SDA for the ninth clock, and it ends the read when the master does not acknowledge.
- R9: SDA is only ever pulled low or released, and the drive changes only while SCL is low.
- R10: A written data byte is stored on the falling SCL edge that ends its eighth bit, before its acknowledge clock. Registers do not change while SCL is high.
- R11: A repeated START restarts the address phase at any point, and a STOP returns the target to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen at the pin |
| sdaIn | input | 1 | Serial data line level as seen at the pin |
| sdaDriveLow | output | 1 | High to pull SDA low; low releases the line |
| tachRps | input | 24 | Measured speed of fans 1 to 3, one byte per fan, fan 1 lowest |
| fanEnable | output | 3 | Enable of fans 1 to 3, fan 1 in bit 0 |
| fanDuty | output | 24 | Duty percentage of fans 1 to 3, one byte per fan, fan 1 lowest |

## Verification
On every cycle the assertions check that the SDA drive changes only while SCL is low, that no stored duty exceeds 100, that the mask and duties hold still while SCL is high, and that the first cycle after reset shows the default mask and duties. Address matching, the pointer rules with wrap and out-of-range values, the split between written duty and read-back speed, the acknowledge pattern, and repeated START handling depend on whole byte sequences. Only the bench's scenarios can show them, by running complete transfers and comparing the outputs and the bytes read back with values worked out from the requirements.

// File: rtl/fanI2cPkg.sv
package fanI2cPkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } busState_e;

  // Strobes from the bus controller to the register datapath
  typedef struct packed {
    logic loadPtr;
    logic incPtr;
    logic wrEn;
  } regStrobe_t;

endpackage

// File: rtl/fanI2cCtrl.sv
module fanI2cCtrl
  import fanI2cPkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h74
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] readByte,
  output logic [BYTE_W-1:0] rxByte,
  output regStrobe_t        strobe,
  output logic              sdaDriveLow
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclNow, sdaNow;
  logic       startSeen, stopSeen, sclRise, sclFall;

  busState_e         state, ackNext;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic              sdaLow;
  logic              masterAck;

  // Two-flop synchronisers plus one delayed copy for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  always_comb begin
    sclNow    = sclSync[1];
    sdaNow    = sdaSync[1];
    startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
    stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;
    sclRise   = sclNow & ~sclPrev;
    sclFall   = ~sclNow & sclPrev;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      ackNext   <= ST_IDLE;
      bitCnt    <= '0;
      shiftReg  <= '0;
      sdaLow    <= 1'b0;
      masterAck <= 1'b0;
      strobe    <= '0;
    end else begin
      strobe <= '0;
      if (startSeen) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
        sdaLow <= 1'b0;
      end else if (stopSeen) begin
        state  <= ST_IDLE;
        sdaLow <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (sclRise && bitCnt != FULL_CNT) begin
              shiftReg <= {shiftReg[BYTE_W-2:0], sdaNow};
              bitCnt   <= bitCnt + 1'b1;
            end else if (sclFall && bitCnt == FULL_CNT) begin
              bitCnt <= '0;
              if (state == ST_ADDR) begin
                if (shiftReg[BYTE_W-1:1] == SLAVE_ADDR) begin
                  sdaLow  <= 1'b1;
                  state   <= ST_ACK;
                  ackNext <= shiftReg[0] ? ST_RDATA : ST_PTR;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_PTR) begin
                sdaLow         <= 1'b1;
                state          <= ST_ACK;
                ackNext        <= ST_WDATA;
                strobe.loadPtr <= 1'b1;
              end else begin
                sdaLow        <= 1'b1;
                state         <= ST_ACK;
                ackNext       <= ST_WDATA;
                strobe.wrEn   <= 1'b1;
                strobe.incPtr <= 1'b1;
              end
            end
          end
          ST_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              state  <= ackNext;
              if (ackNext == ST_RDATA) begin
                shiftReg <= readByte;
                sdaLow   <= ~readByte[BYTE_W-1];
              end else begin
                sdaLow <= 1'b0;
              end
            end
          end
          ST_RDATA: begin
            if (sclFall) begin
              if (bitCnt == LAST_BIT) begin
                sdaLow        <= 1'b0;
                bitCnt        <= '0;
                state         <= ST_RACK;
                strobe.incPtr <= 1'b1;
              end else begin
                bitCnt   <= bitCnt + 1'b1;
                sdaLow   <= ~shiftReg[BYTE_W-2];
                shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (sclRise) begin
              masterAck <= ~sdaNow;
            end else if (sclFall) begin
              if (masterAck) begin
                shiftReg <= readByte;
                sdaLow   <= ~readByte[BYTE_W-1];
                bitCnt   <= '0;
                state    <= ST_RDATA;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: begin
            sdaLow <= 1'b0;
          end
        endcase
      end
    end
  end

  assign rxByte      = shiftReg;
  assign sdaDriveLow = sdaLow;

endmodule

// File: rtl/fanRegFile.sv
module fanRegFile
  import fanI2cPkg::*;
#(
  parameter int NUM_FANS   = 3,
  parameter int DUTY_MAX   = 100,
  parameter int DUTY_RESET = 30
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  regStrobe_t                 strobe,
  input  logic [BYTE_W-1:0]          rxByte,
  input  logic [NUM_FANS*BYTE_W-1:0] tachRps,
  output logic [BYTE_W-1:0]          readByte,
  output logic [NUM_FANS-1:0]        fanEnable,
  output logic [NUM_FANS*BYTE_W-1:0] fanDuty
);

  localparam int NUM_REGS = NUM_FANS + 1;
  localparam int PTR_W    = $clog2(NUM_REGS);
  localparam logic [PTR_W-1:0]  LAST_PTR  = PTR_W'(NUM_FANS);
  localparam logic [BYTE_W-1:0] LAST_REG  = BYTE_W'(NUM_FANS);
  localparam logic [BYTE_W-1:0] DUTY_LIM  = BYTE_W'(DUTY_MAX);
  localparam logic [BYTE_W-1:0] DUTY_INIT = BYTE_W'(DUTY_RESET);

  logic [PTR_W-1:0]  ptr;
  logic [BYTE_W-1:0] dutyIn;

  // Pointer: loaded from the pointer byte, advanced after each data byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strobe.loadPtr) begin
      ptr <= (rxByte <= LAST_REG) ? rxByte[PTR_W-1:0] : '0;
    end else if (strobe.incPtr) begin
      ptr <= (ptr == LAST_PTR) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fanEnable <= '1;
    end else if (strobe.wrEn && ptr == '0) begin
      fanEnable <= rxByte[NUM_FANS-1:0];
    end
  end

  assign dutyIn = (rxByte > DUTY_LIM) ? DUTY_LIM : rxByte;

  for (genvar k = 0; k < NUM_FANS; k++) begin : g_duty
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fanDuty[k*BYTE_W +: BYTE_W] <= DUTY_INIT;
      end else if (strobe.wrEn && ptr == PTR_W'(k + 1)) begin
        fanDuty[k*BYTE_W +: BYTE_W] <= dutyIn;
      end
    end
  end

  // Read side: mask at index 0, measured speeds above it
  always_comb begin
    readByte = '0;
    if (ptr == '0) begin
      readByte[NUM_FANS-1:0] = fanEnable;
    end
    for (int k = 0; k < NUM_FANS; k++) begin
      if (ptr == PTR_W'(k + 1)) begin
        readByte = tachRps[k*BYTE_W +: BYTE_W];
      end
    end
  end

endmodule

// File: rtl/fanI2cTarget.sv
module fanI2cTarget
  import fanI2cPkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h74,
  parameter int NUM_FANS   = 3,
  parameter int DUTY_MAX   = 100,
  parameter int DUTY_RESET = 30
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaDriveLow,
  input  logic [NUM_FANS*8-1:0] tachRps,
  output logic [NUM_FANS-1:0]   fanEnable,
  output logic [NUM_FANS*8-1:0] fanDuty
);

  regStrobe_t        strobe;
  logic [BYTE_W-1:0] rxByte;
  logic [BYTE_W-1:0] readByte;

  fanI2cCtrl #(
    .SLAVE_ADDR(SLAVE_ADDR)
  ) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .readByte   (readByte),
    .rxByte     (rxByte),
    .strobe     (strobe),
    .sdaDriveLow(sdaDriveLow)
  );

  fanRegFile #(
    .NUM_FANS  (NUM_FANS),
    .DUTY_MAX  (DUTY_MAX),
    .DUTY_RESET(DUTY_RESET)
  ) regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rxByte   (rxByte),
    .tachRps  (tachRps),
    .readByte (readByte),
    .fanEnable(fanEnable),
    .fanDuty  (fanDuty)
  );

endmodule

// File: rtl/fanI2cTarget_chk.sv
module fanI2cTarget_chk #(
  parameter int NUM_FANS   = 3,
  parameter int DUTY_MAX   = 100,
  parameter int DUTY_RESET = 30
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclIn,
  input logic                  sdaDriveLow,
  input logic [NUM_FANS-1:0]   fanEnable,
  input logic [NUM_FANS*8-1:0] fanDuty
);

  localparam logic [7:0] DUTY_LIM  = 8'(DUTY_MAX);
  localparam logic [7:0] DUTY_INIT = 8'(DUTY_RESET);

  logic rstQ;
  always_ff @(posedge clk) rstQ <= rstN;

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaDriveLow) || $fell(sdaDriveLow)) |-> !sclIn); // R9

  AST_MASK_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    sclIn |=> $stable(fanEnable)); // R10

  AST_DUTY_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    sclIn |=> $stable(fanDuty)); // R10

  AST_RESET_MASK: assert property (@(posedge clk) disable iff (!rstN)
    !rstQ |-> fanEnable == '1); // R6

  AST_RESET_DUTY: assert property (@(posedge clk) disable iff (!rstN)
    !rstQ |-> fanDuty == {NUM_FANS{DUTY_INIT}}); // R6

  for (genvar k = 0; k < NUM_FANS; k++) begin : g_cap
    AST_DUTY_CAP: assert property (@(posedge clk) disable iff (!rstN)
      fanDuty[k*8 +: 8] <= DUTY_LIM); // R4
  end

endmodule

bind fanI2cTarget fanI2cTarget_chk #(
  .NUM_FANS  (NUM_FANS),
  .DUTY_MAX  (DUTY_MAX),
  .DUTY_RESET(DUTY_RESET)
) chkInst (
  .clk        (clk),
  .rstN       (rstN),
  .sclIn      (sclIn),
  .sdaDriveLow(sdaDriveLow),
  .fanEnable  (fanEnable),
  .fanDuty    (fanDuty)
);

// File: tb/fanI2cTarget_test.sv
module fanI2cTarget_test;

  localparam int QTR = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclDrv = 1'b1;
  logic        masterSda = 1'b1;
  logic        sdaIn;
  logic        sdaDriveLow;
  logic [23:0] tachRps = 24'h0;
  logic [2:0]  fanEnable;
  logic [23:0] fanDuty;

  int checkCount = 0;
  int failCount = 0;
  int r9Bad = 0;
  logic lastDrive = 1'b0;

  always #4 clk = ~clk;

  assign sdaIn = masterSda & ~sdaDriveLow;

  fanI2cTarget uut (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclDrv),
    .sdaIn      (sdaIn),
    .sdaDriveLow(sdaDriveLow),
    .tachRps    (tachRps),
    .fanEnable  (fanEnable),
    .fanDuty    (fanDuty)
  );

  // R9 monitor at the ports: drive must not change while SCL is high
  always @(negedge clk) begin
    if (rstN && (sdaDriveLow !== lastDrive) && sclDrv) r9Bad++;
    lastDrive = sdaDriveLow;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitQ;
    repeat (QTR) @(posedge clk);
    #1;
  endtask

  task automatic busStart;
    masterSda = 1'b1; waitQ;
    sclDrv = 1'b1;    waitQ;
    masterSda = 1'b0; waitQ;
    sclDrv = 1'b0;    waitQ;
  endtask

  task automatic busStop;
    masterSda = 1'b0; waitQ;
    sclDrv = 1'b1;    waitQ;
    masterSda = 1'b1; waitQ;
  endtask

  task automatic sendBits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      masterSda = b[i]; waitQ;
      sclDrv = 1'b1; waitQ; waitQ;
      sclDrv = 1'b0; waitQ;
    end
  endtask

  task automatic ackClock(output logic acked);
    masterSda = 1'b1; waitQ;
    sclDrv = 1'b1;    waitQ;
    acked = ~sdaIn;   waitQ;
    sclDrv = 1'b0;    waitQ;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    sendBits(b);
    ackClock(acked);
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      waitQ;
      sclDrv = 1'b1; waitQ;
      b[i] = sdaIn;  waitQ;
      sclDrv = 1'b0; waitQ;
    end
    masterSda = ~giveAck; waitQ;
    sclDrv = 1'b1; waitQ; waitQ;
    sclDrv = 1'b0; waitQ;
    masterSda = 1'b1;
  endtask

  task automatic testReset;
    check("R6 mask after reset", 32'(fanEnable), 32'h7);
    check("R6 fan1 duty after reset", 32'(fanDuty[7:0]), 32'd30);
    check("R6 fan2 duty after reset", 32'(fanDuty[15:8]), 32'd30);
    check("R6 fan3 duty after reset", 32'(fanDuty[23:16]), 32'd30);
    check("R6 SDA released after reset", 32'(sdaDriveLow), 32'h0);
  endtask

  task automatic testMaskWrite;
    logic a;
    busStart;
    sendByte(8'hE8, a); check("R8 ack own write address", 32'(a), 32'h1);
    sendByte(8'h00, a); check("R8 ack pointer byte", 32'(a), 32'h1);
    sendBits(8'h05);
    check("R10 mask stored before ack clock", 32'(fanEnable), 32'h5);
    ackClock(a);        check("R8 ack data byte", 32'(a), 32'h1);
    busStop;
    check("R3 mask output", 32'(fanEnable), 32'h5);
  endtask

  task automatic testBurstWrite;
    logic a;
    busStart;
    sendByte(8'hE8, a);
    sendByte(8'h01, a);
    sendByte(8'd50, a);
    sendByte(8'd200, a);
    sendByte(8'd100, a);
    busStop;
    check("R4 fan1 duty", 32'(fanDuty[7:0]), 32'd50);
    check("R4 fan2 duty clamped", 32'(fanDuty[15:8]), 32'd100);
    check("R7 fan3 duty via increment", 32'(fanDuty[23:16]), 32'd100);
    busStart;
    sendByte(8'hE8, a);
    sendByte(8'h03, a);
    sendByte(8'd10, a);
    sendByte(8'h02, a);
    busStop;
    check("R7 fan3 duty before wrap", 32'(fanDuty[23:16]), 32'd10);
    check("R7 write wraps to mask", 32'(fanEnable), 32'h2);
  endtask

  task automatic testClampEdge;
    logic a;
    busStart;
    sendByte(8'hE8, a);
    sendByte(8'h01, a);
    sendByte(8'd100, a);
    sendByte(8'd101, a);
    sendByte(8'd0, a);
    busStop;
    check("R4 duty 100 kept", 32'(fanDuty[7:0]), 32'd100);
    check("R4 duty 101 clamped", 32'(fanDuty[15:8]), 32'd100);
    check("R4 duty 0 kept", 32'(fanDuty[23:16]), 32'd0);
  endtask

  task automatic testRead;
    logic a;
    logic [7:0] b;
    tachRps = 24'h332211;
    busStart;
    sendByte(8'hE8, a);
    sendByte(8'h00, a);
    busStart;
    sendByte(8'hE9, a); check("R11 ack read address after repeated start", 32'(a), 32'h1);
    recvByte(1'b1, b);  check("R3 read mask", 32'(b), 32'h02);
    recvByte(1'b1, b);  check("R5 read fan1 speed", 32'(b), 32'h11);
    recvByte(1'b1, b);  check("R5 read fan2 speed", 32'(b), 32'h22);
    recvByte(1'b1, b);  check("R5 read fan3 speed", 32'(b), 32'h33);
    recvByte(1'b0, b);  check("R7 read wraps to mask", 32'(b), 32'h02);
    check("R8 SDA released after master nack", 32'(sdaDriveLow), 32'h0);
    busStop;
    check("R11 SDA released after stop", 32'(sdaDriveLow), 32'h0);
    check("R5 duty unchanged by read", 32'(fanDuty[7:0]), 32'd100);
  endtask

  task automatic testForeign;
    logic a;
    logic [7:0] b;
    busStart;
    sendByte(8'hEA, a); check("R1 no ack for 0x75 write", 32'(a), 32'h0);
    sendByte(8'h00, a); check("R1 no ack for foreign pointer", 32'(a), 32'h0);
    sendByte(8'h07, a); check("R1 no ack for foreign data", 32'(a), 32'h0);
    busStop;
    check("R1 mask unchanged", 32'(fanEnable), 32'h2);
    busStart;
    sendByte(8'hEB, a); check("R1 no ack for 0x75 read", 32'(a), 32'h0);
    recvByte(1'b0, b);  check("R1 foreign read sees released line", 32'(b), 32'hFF);
    busStop;
  endtask

  task automatic testPtrRange;
    logic a;
    logic [7:0] b;
    busStart;
    sendByte(8'hE8, a);
    sendByte(8'h09, a);
    sendByte(8'h07, a);
    busStop;
    check("R2 pointer above 3 selects mask", 32'(fanEnable), 32'h7);
    check("R2 duty untouched", 32'(fanDuty[7:0]), 32'd100);
    busStart;
    sendByte(8'hE8, a);
    sendByte(8'h02, a);
    busStart;
    sendByte(8'hE9, a);
    recvByte(1'b0, b);  check("R2 pointer 2 reads fan2 speed", 32'(b), 32'h22);
    busStop;
  endtask

  task automatic finishRun;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    testReset;
    testMaskWrite;
    testBurstWrite;
    testClampEdge;
    testRead;
    testForeign;
    testPtrRange;
    check("R9 drive changed only with SCL low", 32'(r9Bad), 32'h0);
    finishRun;
  end

endmodule